// File: doc/BRIEF.md
# Single-channel DMA transfer engine

The block is one DMA channel. Software programs a source address, a destination address, a byte count, a timing word and a configuration word through a small register port. Setting the start bit in the configuration word launches the copy. The engine reads from the source side and writes to the destination side through a single request/acknowledge memory port. A byte-lane staging buffer between the two sides lets the source and destination use different access widths.

Each side has its own settings: access width, burst length, address mode and request type. A side whose request type is not memory waits for its data-request line before the first beat of every burst. After every burst it stays idle for a programmable number of cycles. The engine raises a one-cycle pulse when half of the bytes have been written and another when the count runs out. It can reload and repeat the transfer without software help. A configuration write with the start bit clear stops it at once.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the channel is idle: `mem_req_o`, `half_o` and `end_o` are 0, and the busy bit (configuration bit 30) and the byte-count readback both read 0.
- R2: The bytes of the source range are copied in order to the destination range, with byte 0 on data lanes 7:0. Width code 0 is 1 byte, code 1 is 2 bytes, code 2 (and 3) is 4 bytes. The source and destination widths may differ. The byte count must be a multiple of both widths.
- R3: A side whose address-mode code has bit 0 set (1 or 3) keeps its address fixed. Codes 0 and 2 advance the address by the side's width after every acknowledged beat.
- R4: Request type code 1 is memory and never waits. A side with any other code issues the first beat of a burst only while `drq_i[code]` is high, and needs no request for the rest of the burst. Burst code 0 is 1 beat, code 1 is 4 beats, codes 2 and 3 are 8 beats.
- R5: The byte-count register (word 3) reads back the bytes not yet written when configuration bit 15 is set, and the programmed count when bit 15 is clear.
- R6: `half_o` pulses for one cycle after the write that first brings the written total to at least half of the count.
- R7: `end_o` pulses for one cycle after the write that completes the count. Without continuous mode, busy (configuration bit 30) then reads 0 and no further memory request is made.
- R8: A side waits timing-field+1 cycles after the last beat of each burst. The next request on that side starts no earlier than field+2 cycles after the cycle in which that beat was acknowledged. The timing word (word 4) holds the source wait in bits 7:0 and the destination wait in bits 23:16.
- R9: A configuration write with bit 31 clear stops a running transfer at once. Busy reads 0 from the next cycle, `mem_req_o` falls, and no `end_o` follows.
- R10: With continuous mode (configuration bit 29), the transfer reloads its addresses and count after every end pulse and starts again. Busy stays 1.
- R11: A start with a byte count of 0 is ignored. Busy stays 0, and no memory request or pulse follows.
- R12: Words 1, 2 and 4 read back as written. The configuration word reads back its stored fields: destination width 26:25, burst 24:23, mode 22:21, type 20:16; source width 10:9, burst 8:7, mode 6:5, type 4:0; bits 29 and 15. Bit 31 always reads 0.
- R13: While a memory request waits for its acknowledge, it holds its address and direction until acknowledged, unless the configuration word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index (0 config, 1 source, 2 destination, 3 count, 4 timing) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| drq_i | input | REQ_N | Data-request lines indexed by request type code |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for a destination write, 0 for a source read |
| mem_addr_o | output | AW | Byte address of the beat |
| mem_size_o | output | 2 | Width code of the beat |
| mem_wdata_o | output | 32 | Write data, low bytes valid |
| mem_ack_i | input | 1 | Acknowledge; read data is valid in the same cycle |
| mem_rdata_i | input | 32 | Read data, low bytes valid |
| half_o | output | 1 | Half-done pulse |
| end_o | output | 1 | End pulse |

## Verification
The assertions check on every cycle that a waiting request stays stable. They also check that the channel makes no request while idle, that the remaining count never grows within a run, that the staging buffer never overfills, and that an end pulse leaves busy equal to the continuous-mode setting. Only the bench scenarios can show the data path and the timing. These cover copies across mixed widths and bursts, a fixed destination address, stalls behind an unasserted request line, the spacing between bursts, the position of the half pulse, halting, continuous repetition and a zero-length start.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam logic [2:0] RA_CFG = 3'd0;
  localparam logic [2:0] RA_SRC = 3'd1;
  localparam logic [2:0] RA_DST = 3'd2;
  localparam logic [2:0] RA_CNT = 3'd3;
  localparam logic [2:0] RA_TIM = 3'd4;
  localparam logic [4:0] RT_MEM = 5'd1;

  typedef struct packed {
    logic [1:0] width;
    logic [1:0] burst;
    logic [1:0] amode;
    logic [4:0] rtype;
  } side_cfg_t;

  typedef enum logic [1:0] {SQ_ARM, SQ_BURST, SQ_GAP} seq_st_e;

  function automatic logic [1:0] norm_width(logic [1:0] c);
    return (c == 2'd3) ? 2'd2 : c;
  endfunction

  function automatic logic [2:0] width_bytes(logic [1:0] c);
    case (c)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [3:0] burst_beats(logic [1:0] c);
    case (c)
      2'd0:    return 4'd1;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(logic [2:0] nbytes);
    case (nbytes)
      3'd1:    return 32'h0000_00ff;
      3'd2:    return 32'h0000_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             busy_i,
  input  logic [CNT_W-1:0] rem_i,
  output logic             load_o,
  output logic             stop_o,
  output logic             cnt_we_o,
  output logic             cont_o,
  output side_cfg_t        src_o,
  output side_cfg_t        dst_o,
  output logic [AW-1:0]    src_base_o,
  output logic [AW-1:0]    dst_base_o,
  output logic [CNT_W-1:0] count_o,
  output logic [7:0]       src_wait_o,
  output logic [7:0]       dst_wait_o
);
  logic        remain_q;
  logic [31:0] tim_q;

  assign load_o   = we_i && (addr_i == RA_CFG) && wdata_i[31];
  assign stop_o   = we_i && (addr_i == RA_CFG) && !wdata_i[31];
  assign cnt_we_o = we_i && (addr_i == RA_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cont_o     <= 1'b0;
      remain_q   <= 1'b0;
      src_o      <= '0;
      dst_o      <= '0;
      src_base_o <= '0;
      dst_base_o <= '0;
      count_o    <= '0;
      tim_q      <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_CFG: begin
          cont_o   <= wdata_i[29];
          remain_q <= wdata_i[15];
          dst_o    <= wdata_i[26:16];
          src_o    <= wdata_i[10:0];
        end
        RA_SRC:  src_base_o <= wdata_i[AW-1:0];
        RA_DST:  dst_base_o <= wdata_i[AW-1:0];
        RA_CNT:  count_o    <= wdata_i[CNT_W-1:0];
        RA_TIM:  tim_q      <= wdata_i;
        default: ;
      endcase
    end
  end

  // timing word: dst block 31:24, dst wait 23:16, src block 15:8, src wait 7:0 (all value-1)
  assign src_wait_o = tim_q[7:0];
  assign dst_wait_o = tim_q[23:16];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CFG: rdata_o = {1'b0, busy_i, cont_o, 2'b00, dst_o, remain_q, 4'b0000, src_o};
      RA_SRC: rdata_o = 32'(src_base_o);
      RA_DST: rdata_o = 32'(dst_base_o);
      RA_CNT: rdata_o = remain_q ? 32'(rem_i) : 32'(count_o);
      RA_TIM: rdata_o = tim_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       beat_done_i,
  input  logic       drq_i,
  input  logic       is_mem_i,
  input  logic [3:0] beats_i,
  input  logic [8:0] gap_i,
  output logic       ready_o
);
  seq_st_e    st_q;
  logic [3:0] left_q;
  logic [8:0] cnt_q;

  assign ready_o = (st_q == SQ_BURST) || ((st_q == SQ_ARM) && (is_mem_i || drq_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_ARM;
      left_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      st_q   <= SQ_ARM;
      left_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        SQ_ARM: if (beat_done_i) begin
          if (beats_i == 4'd1) begin
            st_q  <= SQ_GAP;
            cnt_q <= gap_i;
          end else begin
            st_q   <= SQ_BURST;
            left_q <= beats_i - 4'd1;
          end
        end
        SQ_BURST: if (beat_done_i) begin
          left_q <= left_q - 4'd1;
          if (left_q == 4'd1) begin
            st_q  <= SQ_GAP;
            cnt_q <= gap_i;
          end
        end
        default: begin
          if (cnt_q <= 9'd1) st_q <= SQ_ARM;
          else cnt_q <= cnt_q - 9'd1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  input  logic          fixed_i,
  input  logic [2:0]    inc_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  addr_o <= '0;
    else if (load_i)              addr_o <= base_i;
    else if (step_i && !fixed_i)  addr_o <= addr_o + AW'(inc_i);
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 24,
  parameter int unsigned REQ_N = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic [REQ_N-1:0] drq_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [1:0]       mem_size_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [31:0]      mem_rdata_i,
  output logic             half_o,
  output logic             end_o
);
  localparam logic [REQ_N-1:0] ONE_HOT0 = REQ_N'(1);

  logic             busy_q, req_q, we_q, half_q, end_q;
  logic [2:0]       fill_q;
  logic [31:0]      buf_q;
  logic [CNT_W-1:0] rem_q, rd_left_q, half_pt_q;

  logic             load, stop, cnt_we, cont_q;
  side_cfg_t        src_c, dst_c;
  logic [AW-1:0]    src_base, dst_base, src_addr, dst_addr;
  logic [CNT_W-1:0] count;
  logic [7:0]       src_wait, dst_wait;

  dma_chan_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy_q), .rem_i(rem_q),
    .load_o(load), .stop_o(stop), .cnt_we_o(cnt_we), .cont_o(cont_q),
    .src_o(src_c), .dst_o(dst_c), .src_base_o(src_base), .dst_base_o(dst_base),
    .count_o(count), .src_wait_o(src_wait), .dst_wait_o(dst_wait)
  );

  logic [2:0] src_w, dst_w;
  assign src_w = width_bytes(src_c.width);
  assign dst_w = width_bytes(dst_c.width);

  logic rd_ack, wr_ack;
  assign rd_ack = req_q && !we_q && mem_ack_i;
  assign wr_ack = req_q && we_q && mem_ack_i;

  logic [CNT_W-1:0] rem_nxt;
  assign rem_nxt = rem_q - CNT_W'(dst_w);

  logic restart;
  assign restart = load || (wr_ack && (rem_nxt == '0) && cont_q && !stop);

  // per-side address and burst sequencing
  logic [1:0]    side_rdy;
  logic [1:0]    side_done;
  side_cfg_t     side_c   [2];
  logic [7:0]    side_wt  [2];
  logic [AW-1:0] side_base[2];
  logic [AW-1:0] side_addr[2];
  logic [2:0]    side_w   [2];

  assign side_c[0]    = src_c;        assign side_c[1]    = dst_c;
  assign side_wt[0]   = src_wait;     assign side_wt[1]   = dst_wait;
  assign side_base[0] = src_base;     assign side_base[1] = dst_base;
  assign side_w[0]    = src_w;        assign side_w[1]    = dst_w;
  assign side_done    = {wr_ack, rd_ack};
  assign src_addr     = side_addr[0];
  assign dst_addr     = side_addr[1];

  for (genvar s = 0; s < 2; s++) begin : g_side
    dma_chan_seq u_seq (
      .clk_i, .rst_ni,
      .clr_i(restart), .beat_done_i(side_done[s]),
      .drq_i(|(drq_i & (ONE_HOT0 << side_c[s].rtype))),
      .is_mem_i(side_c[s].rtype == RT_MEM),
      .beats_i(burst_beats(side_c[s].burst)),
      .gap_i({1'b0, side_wt[s]} + 9'd1),
      .ready_o(side_rdy[s])
    );
    dma_chan_addr #(.AW(AW)) u_addr (
      .clk_i, .rst_ni,
      .load_i(restart), .base_i(side_base[s]), .step_i(side_done[s]),
      .fixed_i(side_c[s].amode[0]), .inc_i(side_w[s]), .addr_o(side_addr[s])
    );
  end

  logic can_rd, can_wr;
  assign can_wr = busy_q && !req_q && (fill_q >= dst_w) && side_rdy[1];
  assign can_rd = busy_q && !req_q && (fill_q < dst_w) && (rd_left_q != '0) && side_rdy[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      req_q     <= 1'b0;
      we_q      <= 1'b0;
      fill_q    <= '0;
      buf_q     <= '0;
      rem_q     <= '0;
      rd_left_q <= '0;
      half_pt_q <= '0;
      half_q    <= 1'b0;
      end_q     <= 1'b0;
    end else begin
      half_q <= 1'b0;
      end_q  <= 1'b0;
      if (stop) begin
        busy_q <= 1'b0;
        req_q  <= 1'b0;
        fill_q <= '0;
      end else if (load) begin
        req_q     <= 1'b0;
        fill_q    <= '0;
        buf_q     <= '0;
        rem_q     <= count;
        rd_left_q <= count;
        half_pt_q <= count >> 1;
        busy_q    <= (count != '0);
      end else begin
        if (cnt_we && !busy_q) rem_q <= reg_wdata_i[CNT_W-1:0];
        if (req_q) begin
          if (mem_ack_i) req_q <= 1'b0;
        end else if (can_wr) begin
          req_q <= 1'b1;
          we_q  <= 1'b1;
        end else if (can_rd) begin
          req_q <= 1'b1;
          we_q  <= 1'b0;
        end
        if (rd_ack) begin
          buf_q     <= buf_q | ((mem_rdata_i & lane_mask(src_w)) << {fill_q, 3'b000});
          fill_q    <= fill_q + src_w;
          rd_left_q <= rd_left_q - CNT_W'(src_w);
        end
        if (wr_ack) begin
          buf_q  <= buf_q >> {dst_w, 3'b000};
          fill_q <= fill_q - dst_w;
          rem_q  <= rem_nxt;
          if ((rem_q > half_pt_q) && (rem_nxt <= half_pt_q)) half_q <= 1'b1;
          if (rem_nxt == '0) begin
            end_q <= 1'b1;
            if (cont_q) begin
              rem_q     <= count;
              rd_left_q <= count;
              half_pt_q <= count >> 1;
            end else begin
              busy_q <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign mem_req_o   = req_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = we_q ? dst_addr : src_addr;
  assign mem_size_o  = we_q ? norm_width(dst_c.width) : norm_width(src_c.width);
  assign mem_wdata_o = buf_q;
  assign half_o      = half_q;
  assign end_o       = end_q;
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_ack_i,
  input logic             end_o,
  input logic             busy_q,
  input logic             cont_q,
  input logic [CNT_W-1:0] rem_q,
  input logic [2:0]       fill_q
);
  logic cfg_wr;
  assign cfg_wr = reg_we_i && (reg_addr_i == 3'd0);

  p_req_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !cfg_wr) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !mem_req_o);

  p_end_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> (busy_q == cont_q));

  p_end_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);

  p_rem_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !end_o && !$past(cfg_wr)) |-> (rem_q <= $past(rem_q)));

  p_fill_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= 3'd4);
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/dma_chan_engine_tb.sv
`timescale 1ns/1ps
module dma_chan_engine_tb;
  localparam int unsigned AW = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] drq = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [1:0]  mem_size;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic        half, done;

  always #4 clk = ~clk;

  dma_chan_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .drq_i(drq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .half_o(half), .end_o(done)
  );

  int unsigned n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model, all activity on the falling edge
  logic [7:0] mem [int unsigned];
  int  cyc = 0, written = 0, wr_at_half = 0, half_cnt = 0, end_cnt = 0;
  int  last_rd_ack = -1000, min_gap = 1000, rd_cnt = 0;
  bit  prev_rd_pend = 1'b0, slow_ack = 1'b1;

  function automatic logic [7:0] rd_byte(int unsigned a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (half) begin half_cnt++; wr_at_half = written; end
    if (done) end_cnt++;
    if (rst_n && mem_req && !mem_we && !prev_rd_pend) begin
      if (cyc - last_rd_ack < min_gap) min_gap = cyc - last_rd_ack;
    end
    if (rst_n && mem_req && (!slow_ack || ($urandom % 4 != 0))) begin
      mem_ack = 1'b1;
      if (mem_we) begin
        for (int i = 0; i < (mem_size == 2'd0 ? 1 : mem_size == 2'd1 ? 2 : 4); i++)
          mem[mem_addr + i] = mem_wdata[8*i +: 8];
        written += (mem_size == 2'd0 ? 1 : mem_size == 2'd1 ? 2 : 4);
      end else begin
        for (int i = 0; i < 4; i++) mem_rdata[8*i +: 8] = rd_byte(mem_addr + i);
        last_rd_ack = cyc;
        rd_cnt++;
      end
    end else begin
      mem_ack = 1'b0;
    end
    prev_rd_pend = rst_n && mem_req && !mem_we && !mem_ack;
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cfgw(bit ld, bit cont, bit remain,
      logic [1:0] dw, logic [1:0] db, logic [1:0] dm, logic [4:0] dt,
      logic [1:0] sw, logic [1:0] sb, logic [1:0] sm, logic [4:0] st);
    return {ld, 1'b0, cont, 2'b00, dw, db, dm, dt, remain, 4'b0000, sw, sb, sm, st};
  endfunction

  task automatic start(input logic [31:0] s, input logic [31:0] d, input int cnt,
                       input logic [31:0] tim, input logic [31:0] cfg);
    wr_reg(3'd1, s);
    wr_reg(3'd2, d);
    wr_reg(3'd3, cnt);
    wr_reg(3'd4, tim);
    wr_reg(3'd0, cfg);
  endtask

  task automatic wait_end(input int prev, input string tag);
    int t = 0;
    while (end_cnt <= prev && t < 5000) begin @(negedge clk); t++; end
    chk(end_cnt > prev, tag, end_cnt, prev + 1);
  endtask

  task automatic fill_src(input int unsigned s, input int unsigned d, input int cnt);
    for (int i = 0; i < cnt; i++) mem[s + i] = 8'($urandom);
    for (int i = 0; i < cnt + 4; i++) mem[d + i] = 8'hEE;
  endtask

  task automatic cmp_copy(input int unsigned s, input int unsigned d, input int cnt, input string tag);
    int bad = 0, first = -1;
    for (int i = 0; i < cnt; i++)
      if (rd_byte(d + i) !== rd_byte(s + i)) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, tag, first < 0 ? 0 : rd_byte(d + first), first < 0 ? 0 : rd_byte(s + first));
    chk(rd_byte(d + cnt) == 8'hEE, {tag, " guard byte"}, rd_byte(d + cnt), 8'hEE);
  endtask

  // one complete memory-to-memory copy with pulse and busy checks
  task automatic run_copy(input int k, input logic [1:0] sw, input logic [1:0] dw,
                          input logic [1:0] sb, input logic [1:0] db, input int cnt);
    int unsigned s = 32'h1000 + k * 32'h200;
    int unsigned d = 32'h9000 + k * 32'h200;
    int h0, e0;
    logic [31:0] r;
    int hw;
    fill_src(s, d, cnt);
    h0 = half_cnt; e0 = end_cnt; written = 0;
    start(s, d, cnt, 32'h0101_0101, cfgw(1, 0, 0, dw, db, 2'd0, 5'd1, sw, sb, 2'd0, 5'd1));
    wait_end(e0, "R7 end pulse after copy");
    repeat (3) @(negedge clk);
    cmp_copy(s, d, cnt, "R2 copied data");
    hw = (dw == 2'd0) ? 1 : (dw == 2'd1) ? 2 : 4;
    chk(half_cnt == h0 + 1, "R6 one half pulse", half_cnt - h0, 1);
    chk(wr_at_half >= cnt / 2 && wr_at_half - hw < cnt / 2, "R6 half pulse position", wr_at_half, cnt / 2);
    chk(end_cnt == e0 + 1, "R7 one end pulse", end_cnt - e0, 1);
    rd_reg(3'd0, r);
    chk(r[30] == 1'b0, "R7 busy clear after end", r[30], 0);
    chk(mem_req == 1'b0, "R7 no request after end", mem_req, 0);
  endtask

  initial begin
    logic [31:0] r;
    int e0, w0, rc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(mem_req == 1'b0 && half == 1'b0 && done == 1'b0, "R1 outputs idle", {mem_req, half, done}, 0);
    rd_reg(3'd0, r);
    chk(r[30] == 1'b0, "R1 busy after reset", r[30], 0);
    rd_reg(3'd3, r);
    chk(r == 32'd0, "R1 count after reset", r, 0);

    // R12 register readback
    wr_reg(3'd1, 32'h1234_5678);
    wr_reg(3'd2, 32'h8765_4320);
    wr_reg(3'd4, 32'hA1B2_C3D4);
    wr_reg(3'd0, cfgw(0, 1, 1, 2'd1, 2'd2, 2'd3, 5'd9, 2'd2, 2'd1, 2'd1, 5'd17));
    rd_reg(3'd1, r); chk(r == 32'h1234_5678, "R12 source readback", r, 32'h1234_5678);
    rd_reg(3'd2, r); chk(r == 32'h8765_4320, "R12 destination readback", r, 32'h8765_4320);
    rd_reg(3'd4, r); chk(r == 32'hA1B2_C3D4, "R12 timing readback", r, 32'hA1B2_C3D4);
    rd_reg(3'd0, r);
    chk(r == cfgw(0, 1, 1, 2'd1, 2'd2, 2'd3, 5'd9, 2'd2, 2'd1, 2'd1, 5'd17), "R12 config readback",
        r, cfgw(0, 1, 1, 2'd1, 2'd2, 2'd3, 5'd9, 2'd2, 2'd1, 2'd1, 5'd17));

    // R2 directed width corners, then random copies
    run_copy(0, 2'd0, 2'd2, 2'd2, 2'd0, 16);
    run_copy(1, 2'd2, 2'd0, 2'd0, 2'd2, 20);
    run_copy(2, 2'd1, 2'd3, 2'd3, 2'd1, 12);
    for (int k = 3; k < 9; k++)
      run_copy(k, 2'($urandom % 3), 2'($urandom % 3), 2'($urandom % 3), 2'($urandom % 3),
               4 * (1 + int'($urandom % 16)));

    // R3 fixed destination address
    fill_src(32'h3000, 32'h3800, 16);
    e0 = end_cnt;
    start(32'h3000, 32'h3800, 16, 32'h0, cfgw(1, 0, 0, 2'd2, 2'd1, 2'd1, 5'd1, 2'd2, 2'd1, 2'd0, 5'd1));
    wait_end(e0, "R3 fixed destination end");
    chk({rd_byte(32'h3803), rd_byte(32'h3802), rd_byte(32'h3801), rd_byte(32'h3800)} ==
        {rd_byte(32'h300F), rd_byte(32'h300E), rd_byte(32'h300D), rd_byte(32'h300C)},
        "R3 fixed address holds last word",
        {rd_byte(32'h3803), rd_byte(32'h3800)}, {rd_byte(32'h300F), rd_byte(32'h300C)});
    chk(rd_byte(32'h3804) == 8'hEE, "R3 no write past fixed address", rd_byte(32'h3804), 8'hEE);

    // R4 and R5: destination gated by drq[5], bursts of 4 beats, remaining readback
    fill_src(32'h4000, 32'h4800, 32);
    written = 0; e0 = end_cnt;
    start(32'h4000, 32'h4800, 32, 32'h0, cfgw(1, 0, 1, 2'd2, 2'd1, 2'd0, 5'd5, 2'd2, 2'd1, 2'd0, 5'd1));
    repeat (20) @(negedge clk);
    chk(written == 0, "R4 no write without request line", written, 0);
    rd_reg(3'd3, r);
    chk(r == 32'd32, "R5 remaining before any write", r, 32);
    @(negedge clk); drq[5] = 1'b1;
    @(negedge clk); drq[5] = 1'b0;
    repeat (40) @(negedge clk);
    chk(written == 16, "R4 one burst of four beats per request", written, 16);
    rd_reg(3'd3, r);
    chk(r == 32'd16, "R5 remaining after one burst", r, 16);
    drq[5] = 1'b1;
    wait_end(e0, "R4 gated transfer end");
    drq[5] = 1'b0;
    cmp_copy(32'h4000, 32'h4800, 32, "R4 gated copy data");
    wr_reg(3'd0, cfgw(0, 0, 0, 2'd2, 2'd1, 2'd0, 5'd5, 2'd2, 2'd1, 2'd0, 5'd1));
    rd_reg(3'd3, r);
    chk(r == 32'd32, "R5 programmed count without remain bit", r, 32);

    // R8 source wait cycles between bursts
    fill_src(32'h5000, 32'h5800, 32);
    e0 = end_cnt; min_gap = 1000; last_rd_ack = -1000; rc = rd_cnt;
    start(32'h5000, 32'h5800, 32, 32'h0000_0003, cfgw(1, 0, 0, 2'd2, 2'd0, 2'd0, 5'd1, 2'd2, 2'd0, 2'd0, 5'd1));
    wait_end(e0, "R8 spaced transfer end");
    chk(rd_cnt - rc == 8, "R8 read beat count", rd_cnt - rc, 8);
    chk(min_gap >= 5, "R8 spacing after source burst", min_gap, 5);
    cmp_copy(32'h5000, 32'h5800, 32, "R8 spaced copy data");

    // R9 halt
    fill_src(32'h6000, 32'h6800, 256);
    e0 = end_cnt;
    start(32'h6000, 32'h6800, 256, 32'h0, cfgw(1, 0, 0, 2'd2, 2'd0, 2'd0, 5'd1, 2'd2, 2'd0, 2'd0, 5'd1));
    repeat (12) @(negedge clk);
    wr_reg(3'd0, 32'h0);
    rd_reg(3'd0, r);
    chk(r[30] == 1'b0, "R9 busy clear after halt", r[30], 0);
    w0 = written;
    rc = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_req) rc++; end
    chk(rc == 0, "R9 no request after halt", rc, 0);
    chk(written == w0 && end_cnt == e0, "R9 nothing moves after halt", written - w0 + end_cnt - e0, 0);

    // R10 continuous repetition
    fill_src(32'h7000, 32'h7800, 8);
    e0 = end_cnt;
    start(32'h7000, 32'h7800, 8, 32'h0, cfgw(1, 1, 0, 2'd2, 2'd0, 2'd0, 5'd1, 2'd2, 2'd0, 2'd0, 5'd1));
    wait_end(e0 + 1, "R10 second end pulse");
    rd_reg(3'd0, r);
    chk(r[30] == 1'b1, "R10 busy stays set", r[30], 1);
    wr_reg(3'd0, 32'h0);
    repeat (2) @(negedge clk);
    cmp_copy(32'h7000, 32'h7800, 8, "R10 repeated copy data");
    rd_reg(3'd0, r);
    chk(r[30] == 1'b0, "R10 halt ends repetition", r[30], 0);

    // R11 zero-length start
    e0 = end_cnt; w0 = half_cnt; rc = 0;
    start(32'h7000, 32'h7800, 0, 32'h0, cfgw(1, 0, 0, 2'd2, 2'd0, 2'd0, 5'd1, 2'd2, 2'd0, 2'd0, 5'd1));
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (mem_req) rc++; end
    rd_reg(3'd0, r);
    chk(r[30] == 1'b0 && rc == 0, "R11 zero count stays idle", {r[30], rc[7:0]}, 0);
    chk(end_cnt == e0 && half_cnt == w0, "R11 no pulse for zero count", end_cnt - e0 + half_cnt - w0, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule